// File: doc/BRIEF.md
# Address-Compare and Operand-Test Flag Unit

This unit produces the five condition-code flags for two register instructions. The first is an address-register compare, which subtracts a source operand from a register. The second is a test, which looks at a register at a chosen operand size. An instruction sequencer drives the register value, the source value, the operation select and the size code, and raises a one-cycle valid strobe. One clock later the unit presents the new flags, and it holds them until the next strobe.

The two operations treat operand size in opposite ways. The compare always subtracts across the full 32 bits. A word-sized source is sign-extended first. The test examines only the bits inside the selected size. Because of this, a word test of a register can report zero while a compare of the same register against zero reports non-zero. The extend flag is never written by either operation, so it keeps the value it had.

Top module: `flag_unit`

## Requirements
- R1: A synchronous reset, `rst` high at a rising clock edge, clears all five flags. `ccr` is {X, N, Z, V, C}, with X in bit 4 and C in bit 0.
- R2: The flags take their new value at the first rising edge at which `valid` is high. While `valid` is low they hold, whatever the other inputs do.
- R3: When `op_test` is 0 (address compare) and `size` is 2'b10 or 2'b11 (long), the unit forms the 32-bit difference `reg_val - src_val`. N is bit 31 of the difference, and Z is 1 when the whole difference is zero.
- R4: When `op_test` is 0 and `size` is 2'b00 or 2'b01, the source is the low 16 bits of `src_val` sign-extended to 32 bits. The subtraction is still 32 bits wide.
- R5: For a compare, C is 1 exactly when the source is larger than the register as an unsigned number, that is, when the subtraction borrows.
- R6: For a compare, V is 1 exactly when the signed difference of register and source falls outside the 32-bit signed range.
- R7: When `op_test` is 1, the size is byte (2'b00), word (2'b01) or long (2'b10/2'b11). N is bit 7, bit 15 or bit 31 of `reg_val`. Z is 1 when bits 7:0, 15:0 or 31:0 are all zero.
- R8: A test always clears V and C.
- R9: Neither operation changes X, so after reset X stays 0.
- R10: A compare against a zero source leaves V and C cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Update strobe for one operation |
| op_test | input | 1 | 0 = address compare, 1 = test |
| size | input | 2 | 00 byte, 01 word, 10/11 long |
| reg_val | input | 32 | Register operand |
| src_val | input | 32 | Source operand (compare only) |
| ccr | output | 5 | Registered flags {X, N, Z, V, C} |

## Verification
Hand-picked patterns cover the edges of each flag:
- A register of 0x0001_0000, tested at word size and compared against a zero word, separates the two size rules.
- A source of 0x8000 against a zero register separates sign extension from zero extension.
- 0x7FFF_FFFF minus -1 isolates signed overflow.
- 0x0000_0180 and 0x8000_0000 show N and Z being taken from the right bit for each size.

A sweep of pseudo-random operands across every select and size then compares the flags against values worked out with signed 64-bit arithmetic. Idle cycles with changing inputs confirm that the flags hold while `valid` is low.

// File: rtl/flag_unit.sv
module flag_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         op_test,
  input  logic [1:0]   size,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] src_val,
  output logic [4:0]   ccr
);
  localparam int HW = 16;
  localparam int BW = 8;

  logic         x_q;
  logic [3:0]   nzvc_q;
  logic         is_long;
  logic [W-1:0] src_ext;
  logic [W:0]   diff;
  logic         c_n, c_z, c_v, c_c;
  logic         t_n, t_z;
  logic [3:0]   nzvc_d;

  assign is_long = size[1];
  assign src_ext = is_long ? src_val : {{(W-HW){src_val[HW-1]}}, src_val[HW-1:0]};
  assign diff    = {1'b0, reg_val} - {1'b0, src_ext};

  assign c_n = diff[W-1];
  assign c_z = (diff[W-1:0] == '0);
  assign c_c = diff[W];
  assign c_v = (reg_val[W-1] != src_ext[W-1]) && (diff[W-1] != reg_val[W-1]);

  always_comb begin
    case (size)
      2'b00:   begin t_n = reg_val[BW-1]; t_z = (reg_val[BW-1:0] == '0); end
      2'b01:   begin t_n = reg_val[HW-1]; t_z = (reg_val[HW-1:0] == '0); end
      default: begin t_n = reg_val[W-1];  t_z = (reg_val == '0); end
    endcase
  end

  assign nzvc_d = op_test ? {t_n, t_z, 2'b00} : {c_n, c_z, c_v, c_c};

  always_ff @(posedge clk) begin
    if (rst) x_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)        nzvc_q <= '0;
    else if (valid) nzvc_q <= nzvc_d;
  end

  assign ccr = {x_q, nzvc_q};

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(ccr));

  p_long_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && !op_test && size[1]) |=> (ccr[2] == ($past(reg_val) == $past(src_val))));

  p_borrow_r5: assert property (@(posedge clk) disable iff (rst)
    (valid && !op_test && size[1]) |=> (ccr[0] == ($past(reg_val) < $past(src_val))));

  p_test_vc_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && op_test) |=> (ccr[1:0] == 2'b00));

  p_x_kept_r9: assert property (@(posedge clk) disable iff (rst)
    valid |=> $stable(ccr[4]));

  p_zero_src_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && !op_test && src_val == '0) |=> (ccr[1:0] == 2'b00));
endmodule

// File: tb/flag_unit_test.sv
module flag_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic        op_test = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [31:0] reg_val = '0;
  logic [31:0] src_val = '0;
  logic [4:0]  ccr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  flag_unit uut (.clk(clk), .rst(rst), .valid(valid), .op_test(op_test),
                 .size(size), .reg_val(reg_val), .src_val(src_val), .ccr(ccr));

  task automatic check(input logic [4:0] got, input logic [4:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: ccr actual %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic t, input logic [1:0] sz,
                                       input logic [31:0] r, input logic [31:0] s);
    longint rs, ss, d;
    logic [31:0] se;
    logic n, z, v, c;
    if (t) begin
      if (sz == 2'b00)      begin n = r[7];  z = (r[7:0] == 0); end
      else if (sz == 2'b01) begin n = r[15]; z = (r[15:0] == 0); end
      else                  begin n = r[31]; z = (r == 0); end
      v = 0; c = 0;
    end else begin
      se = sz[1] ? s : 32'($signed(s[15:0]));
      rs = longint'($signed(r));
      ss = longint'($signed(se));
      d  = rs - ss;
      v  = (d > 64'sd2147483647) || (d < -64'sd2147483648);
      c  = (longint'(r) < longint'(se));
      n  = d[31];
      z  = (d[31:0] == 0);
    end
    return {1'b0, n, z, v, c};
  endfunction

  task automatic issue(input logic t, input logic [1:0] sz, input logic [31:0] r,
                       input logic [31:0] s, input logic [4:0] exp, input string tag);
    @(negedge clk);
    op_test = t; size = sz; reg_val = r; src_val = s; valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (!rst && valid) begin
        #1;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: ccr actual %b expected <none queued>", ccr);
        end else begin
          check(ccr, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: ccr actual %b expected run to finish", ccr);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lr, ls;
    logic [4:0]  last;
    repeat (3) @(negedge clk);
    check(ccr, 5'b00000, "R1 reset");
    rst = 1'b0;

    issue(1, 2'b01, 32'h0001_0000, 0, 5'b00100, "R7 word test low half zero");
    issue(0, 2'b01, 32'h0001_0000, 0, 5'b00000, "R3 R10 compare full width vs zero");
    issue(0, 2'b01, 32'h0000_0000, 32'h0000_8000, 5'b00001, "R4 sign-extended word source");
    issue(0, 2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'b01011, "R6 R5 signed overflow");
    issue(1, 2'b00, 32'h0000_0180, 32'hFFFF_FFFF, 5'b01000, "R7 R8 byte test bit7");
    issue(1, 2'b10, 32'h8000_0000, 0, 5'b01000, "R7 long test");
    issue(1, 2'b01, 32'h8000_0000, 0, 5'b00100, "R7 word test same reg");
    issue(0, 2'b11, 32'h1234_5678, 32'h1234_5678, 5'b00100, "R3 equal long");
    issue(0, 2'b00, 32'hFFFF_FFFF, 32'h0000_FFFF, 5'b00100, "R4 byte code as word");
    issue(0, 2'b10, 32'h8000_0000, 32'h0000_0001, 5'b00010, "R6 negative overflow");
    issue(0, 2'b10, 32'h0000_0000, 32'h0000_0000, 5'b00100, "R10 zero minus zero");
    issue(0, 2'b00, 32'h0000_0005, 32'h0000_0009, 5'b01001, "R5 word borrow");

    @(negedge clk);
    last = ccr;
    for (int i = 0; i < 5; i++) begin
      op_test = i[0]; size = i[1:0]; reg_val = 32'h0 + i; src_val = 32'hFFFF_0000 >> i;
      @(negedge clk);
      check(ccr, last, "R2 hold while idle");
    end

    lr = 32'h1357_9BDF;
    ls = 32'h2468_ACE0;
    for (int i = 0; i < 400; i++) begin
      lr = lr * 32'd1664525 + 32'd1013904223;
      ls = ls ^ (ls << 13); ls = ls ^ (ls >> 17); ls = ls ^ (ls << 5);
      if (i % 7 == 0) ls = lr;
      if (i % 11 == 0) ls = 0;
      issue(i[0], i[2:1], lr, ls, model(i[0], i[2:1], lr, ls), "R3-R10 sweep (R9 X)");
    end

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: %0d results actual missing expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule